// File: doc/BRIEF.md
# Permanent Write-Lock Controller

This block sits beside the serial-memory protocol engine and owns write protection for a byte-addressed array. Two sources can block a write. A one-time software lock covers the lower half of the array. A hardware protect pin covers the whole array. The protocol engine passes in decoded bus events as single-cycle strobes: an address byte with its type (lock-command type or normal type) and its direction bit, a received data byte, and a stop condition. The block answers with an acknowledge decision for each address byte and each data byte. It also drives a busy flag for the internal programming cycle and a combinational write-permit for any array address that the write path presents.

The lock command is a lock-type address with direction write, then two dummy bytes, then a stop. The lock bit is set when that stop arrives while the protect pin is low. A lock-type address with direction read is a status query. It is acknowledged only while the lock is clear, and it changes nothing. Once the lock is set, no bus sequence can clear it. The lock bit stands in for a non-volatile cell: a load strobe restores its value at power-up, and the reset clears it.

Top module: `plock_ctrl`

## Requirements
- R1: After reset, `locked` and `busy` are 0, `addr_ack` and `byte_ack` are 0 while no event strobe is high, and `wr_permit` is 1 while `wp_pin` is 0.
- R2: A lock-type address (`ev_lock_type`=1) is acknowledged in the same cycle only while `locked`=0 and `busy`=0. Once locked, it is never acknowledged, for either value of `ev_rw`.
- R3: A lock-type address with `ev_rw`=1 is a query. Neither it nor the bytes and stop that follow it change `locked` or `busy`, and `byte_ack` stays 0 for those bytes.
- R4: An acknowledged lock-type write address, followed by at least two `ev_byte` strobes and then `ev_stop` while `wp_pin`=0, makes `locked` read 1 from the cycle after the stop.
- R5: If `wp_pin` is 1 at the cycle of that stop, the command is dropped: `locked` stays 0 and `busy` stays 0.
- R6: A stop after fewer than two bytes, or a new address before the stop, leaves `locked` unchanged and starts no busy period.
- R7: A successful lock command holds `busy` at 1 for exactly WR_CYCLES cycles, starting the cycle after the stop. No address of either type is acknowledged while `busy`=1.
- R8: A normal-type address (`ev_lock_type`=0) is acknowledged whenever `busy`=0. After an acknowledged normal write address, every data byte is acknowledged until the stop, whatever the values of `wp_pin` and `locked`.
- R9: `wr_permit` is 0 for every address when `wp_pin`=1. It is 0 for addresses with the top bit 0 (lower half) when `locked`=1. It is 1 in every other case.
- R10: `locked` is changed only by reset (cleared) or by `nv_load` (loaded from `nv_value`), apart from the setting in R4. No bus event clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_load | input | 1 | Restore strobe for the lock bit |
| nv_value | input | 1 | Value restored into the lock bit |
| wp_pin | input | 1 | Hardware protect pin, high blocks all writes |
| ev_addr | input | 1 | Address byte received (strobe) |
| ev_lock_type | input | 1 | Address byte is the lock-command type |
| ev_rw | input | 1 | Direction bit of the address byte, 1 = read |
| ev_byte | input | 1 | Data byte received (strobe) |
| ev_stop | input | 1 | Stop condition seen (strobe) |
| chk_addr | input | AW | Array address presented by the write path |
| addr_ack | output | 1 | Acknowledge for the current address byte |
| byte_ack | output | 1 | Acknowledge for the current data byte |
| busy | output | 1 | Internal programming cycle running |
| locked | output | 1 | Lock bit state |
| wr_permit | output | 1 | Write allowed at `chk_addr` |

## Verification
The assertions assume that the protocol engine raises at most one of `ev_addr`, `ev_byte` and `ev_stop` in a cycle, and that each strobe lasts one cycle. They also assume that `nv_load` is used only as a restore pulse and never during a lock command. The bench drives each event from its own task: the task raises one strobe at a falling edge and lowers it at the next, with at least one idle cycle between events. It pulses `nv_load` only while the bus is idle. The permit check sweeps all array addresses under each combination of `wp_pin` and the lock bit.

// File: rtl/plock_pkg.sv
package plock_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_NORM = 3'd1,
    ST_DUMA = 3'd2,
    ST_DUMD = 3'd3,
    ST_ARM  = 3'd4
  } seq_st_e;
endpackage

// File: rtl/plock_seq.sv
module plock_seq
  import plock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_addr,
  input  logic ev_lock_type,
  input  logic ev_rw,
  input  logic ev_byte,
  input  logic ev_stop,
  input  logic wp_pin,
  input  logic locked,
  input  logic busy,
  output logic addr_ack,
  output logic byte_ack,
  output logic commit
);
  seq_st_e st_q, st_d;

  always_comb begin
    addr_ack = ev_addr & ~busy & (~ev_lock_type | ~locked);
    byte_ack = ev_byte & (st_q != ST_IDLE);
    commit   = ev_stop & (st_q == ST_ARM) & ~wp_pin;
  end

  always_comb begin
    st_d = st_q;
    if (ev_addr) begin
      if (!addr_ack || ev_rw) st_d = ST_IDLE;
      else if (ev_lock_type)  st_d = ST_DUMA;
      else                    st_d = ST_NORM;
    end else if (ev_stop) begin
      st_d = ST_IDLE;
    end else if (ev_byte) begin
      case (st_q)
        ST_DUMA: st_d = ST_DUMD;
        ST_DUMD: st_d = ST_ARM;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R2
  lock_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr && ev_lock_type && locked) |-> !addr_ack);
  // R7
  busy_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr && busy) |-> !addr_ack);
  // R3
  query_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr && ev_rw) |=> (st_q == ST_IDLE));
  // R6
  early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && st_q != ST_ARM) |-> !commit);
endmodule

// File: rtl/plock_timer.sv
module plock_timer #(
  parameter int WR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)            cnt_d = LOAD;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/plock_guard.sv
module plock_guard #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nv_load,
  input  logic          nv_value,
  input  logic          commit,
  input  logic          wp_pin,
  input  logic [AW-1:0] chk_addr,
  output logic          locked,
  output logic          wr_permit
);
  localparam int HI = AW - 1;

  logic lock_q, lock_d, lock_en;

  always_comb begin
    lock_en = nv_load | commit;
    lock_d  = nv_load ? nv_value : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  assign locked    = lock_q;
  assign wr_permit = ~wp_pin & ~(lock_q & ~chk_addr[HI]);

  // R10
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(nv_load));
  // R9
  permit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !chk_addr[HI]) |-> !wr_permit);
  // R9
  permit_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_pin |-> !wr_permit);
endmodule

// File: rtl/plock_ctrl.sv
module plock_ctrl #(
  parameter int AW        = 8,
  parameter int WR_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nv_load,
  input  logic          nv_value,
  input  logic          wp_pin,
  input  logic          ev_addr,
  input  logic          ev_lock_type,
  input  logic          ev_rw,
  input  logic          ev_byte,
  input  logic          ev_stop,
  input  logic [AW-1:0] chk_addr,
  output logic          addr_ack,
  output logic          byte_ack,
  output logic          busy,
  output logic          locked,
  output logic          wr_permit
);
  logic [1:0] rst_sync_q;
  logic       rst_s;
  logic       commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  plock_seq u_seq (
    .clk(clk), .rst_n(rst_s),
    .ev_addr(ev_addr), .ev_lock_type(ev_lock_type), .ev_rw(ev_rw),
    .ev_byte(ev_byte), .ev_stop(ev_stop), .wp_pin(wp_pin),
    .locked(locked), .busy(busy),
    .addr_ack(addr_ack), .byte_ack(byte_ack), .commit(commit)
  );

  plock_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_s), .start(commit), .busy(busy)
  );

  plock_guard #(.AW(AW)) u_guard (
    .clk(clk), .rst_n(rst_s),
    .nv_load(nv_load), .nv_value(nv_value), .commit(commit),
    .wp_pin(wp_pin), .chk_addr(chk_addr),
    .locked(locked), .wr_permit(wr_permit)
  );

  // R5
  wp_drop_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ev_stop && wp_pin && !nv_load && !locked) |=> !locked);
  // R3
  query_keep_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ev_addr && ev_rw && !nv_load) |=> $stable(locked));
endmodule

// File: tb/sim_plock_ctrl.sv
module sim_plock_ctrl;
  localparam int AW = 8;
  localparam int WRC = 8;

  logic clk = 1'b0;
  logic rst_n, nv_load, nv_value, wp_pin;
  logic ev_addr, ev_lock_type, ev_rw, ev_byte, ev_stop;
  logic [AW-1:0] chk_addr;
  logic addr_ack, byte_ack, busy, locked, wr_permit;

  int n_chk = 0;
  int n_fail = 0;
  logic ack_s;

  always #2.5 clk = ~clk;

  plock_ctrl #(.AW(AW), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .nv_load(nv_load), .nv_value(nv_value),
    .wp_pin(wp_pin), .ev_addr(ev_addr), .ev_lock_type(ev_lock_type),
    .ev_rw(ev_rw), .ev_byte(ev_byte), .ev_stop(ev_stop),
    .chk_addr(chk_addr), .addr_ack(addr_ack), .byte_ack(byte_ack),
    .busy(busy), .locked(locked), .wr_permit(wr_permit)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_addr(input logic lt, input logic rw);
    @(negedge clk);
    ev_addr = 1'b1; ev_lock_type = lt; ev_rw = rw;
    #1 ack_s = addr_ack;
    @(negedge clk);
    ev_addr = 1'b0; ev_lock_type = 1'b0; ev_rw = 1'b0;
  endtask

  task automatic send_byte();
    @(negedge clk);
    ev_byte = 1'b1;
    #1 ack_s = byte_ack;
    @(negedge clk);
    ev_byte = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk);
    ev_stop = 1'b1;
    @(negedge clk);
    ev_stop = 1'b0;
  endtask

  task automatic restore(input logic v);
    @(negedge clk);
    nv_load = 1'b1; nv_value = v;
    @(negedge clk);
    nv_load = 1'b0; nv_value = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < (1 << AW); a++) begin
      chk_addr = AW'(a);
      #1;
      chk(req, int'(wr_permit),
          int'(!wp_pin && !(locked && a < (1 << (AW-1)))));
    end
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int nb;
    rst_n = 1'b0; nv_load = 1'b0; nv_value = 1'b0; wp_pin = 1'b0;
    ev_addr = 1'b0; ev_lock_type = 1'b0; ev_rw = 1'b0;
    ev_byte = 1'b0; ev_stop = 1'b0; chk_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 locked", int'(locked), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 addr_ack", int'(addr_ack), 0);
    chk("R1 byte_ack", int'(byte_ack), 0);
    chk("R1 permit", int'(wr_permit), 1);

    // R9 sweeps, unlocked
    wp_pin = 1'b0; sweep("R9 wp0 unlocked");
    wp_pin = 1'b1; sweep("R9 wp1 unlocked");
    wp_pin = 1'b0;

    // R3 query acknowledged, no change
    send_addr(1'b1, 1'b1);
    chk("R3 query ack", int'(ack_s), 1);
    send_byte();
    chk("R3 byte after query", int'(ack_s), 0);
    send_stop();
    chk("R3 locked", int'(locked), 0);
    chk("R3 busy", int'(busy), 0);

    // R8 normal write: all bytes acked, wp high
    wp_pin = 1'b1;
    send_addr(1'b0, 1'b0);
    chk("R8 addr ack", int'(ack_s), 1);
    for (int i = 0; i < 3; i++) begin
      send_byte();
      chk("R8 byte ack wp1", int'(ack_s), 1);
    end
    send_stop();
    chk("R8 no busy", int'(busy), 0);

    // R5 lock command with wp high dropped
    send_addr(1'b1, 1'b0);
    chk("R2 lock addr ack", int'(ack_s), 1);
    send_byte(); chk("R5 dummy ack", int'(ack_s), 1);
    send_byte(); chk("R5 dummy ack", int'(ack_s), 1);
    send_stop();
    chk("R5 locked", int'(locked), 0);
    chk("R5 busy", int'(busy), 0);
    wp_pin = 1'b0;

    // R6 short command: one byte
    send_addr(1'b1, 1'b0);
    send_byte();
    send_stop();
    chk("R6 one byte", int'(locked), 0);
    chk("R6 busy", int'(busy), 0);
    // R6 new address before stop
    send_addr(1'b1, 1'b0);
    send_byte(); send_byte();
    send_addr(1'b0, 1'b0);
    send_stop();
    chk("R6 restart", int'(locked), 0);
    chk("R6 busy restart", int'(busy), 0);

    // R4 full command sets lock, R7 busy window
    send_addr(1'b1, 1'b0);
    send_byte(); send_byte(); send_byte();
    @(negedge clk);
    ev_stop = 1'b1;
    @(negedge clk);
    ev_stop = 1'b0;
    chk("R4 locked", int'(locked), 1);
    ev_addr = 1'b1; ev_lock_type = 1'b0;
    #1 chk("R7 normal nak busy", int'(addr_ack), 0);
    ev_addr = 1'b0;
    wait_busy(nb);
    chk("R7 busy length", nb, WRC);

    // R2 after lock: no lock-type ack either way; R8 normal ack
    send_addr(1'b1, 1'b0);
    chk("R2 locked write nak", int'(ack_s), 0);
    send_addr(1'b1, 1'b1);
    chk("R2 locked query nak", int'(ack_s), 0);
    send_addr(1'b0, 1'b0);
    chk("R8 normal ack", int'(ack_s), 1);
    send_byte();
    chk("R8 byte ack locked", int'(ack_s), 1);
    send_stop();
    chk("R10 bus keeps lock", int'(locked), 1);

    // R9 sweeps, locked
    sweep("R9 wp0 locked");
    wp_pin = 1'b1; sweep("R9 wp1 locked");
    wp_pin = 1'b0;

    // R10 restore path
    restore(1'b0);
    chk("R10 restore 0", int'(locked), 0);
    restore(1'b1);
    chk("R10 restore 1", int'(locked), 1);
    rst_n = 1'b0;
    #1 chk("R10 reset clears", int'(locked), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send_addr(1'b1, 1'b1);
    chk("R2 ack after reset", int'(ack_s), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule